// File: doc/BRIEF.md
# Stack Frame Entry/Exit Sequencer

This block carries out the register save and restore work of a function's stack frame as a multi-cycle sequence. A start pulse brings in the operation (build or tear down), a 12-bit selection mask over the registers r20 to r31, a 5-bit frame-size immediate counted in words, and a return-register index. The block reads the stack pointer once at start and steps a private copy of it. It moves one selected register per memory access through a single-word memory port with a ready handshake. At the end it writes the new stack pointer back in one cycle.

When it builds a frame, the block saves the selected registers to descending addresses, lowest register number first, so that lower-numbered registers sit at higher addresses. It then lowers the pointer further by the local area. When it tears a frame down, it first releases the local area and then reloads the registers in the mirrored order, highest register number first, raising the pointer after each word. A nonzero return index makes the block report a jump to the value held in that register once all reloads are done.

Instruction decode, the register file and the memory itself sit outside the block. The register file is reached through a combinational read port and a one-cycle write strobe.

Top module: `frame_seq`

## Requirements
- R1: On a build (op_dispose=0), the block visits mask bit i from 0 upward. Bit i selects register index 20+i. For each set bit it issues one word write whose address is the running pointer minus 4 and whose data is that register's value. After the write it lowers the running pointer by 4.
- R2: When a build completes, the pointer written back equals the start pointer minus 4 per set mask bit minus 4 times the frame immediate.
- R3: On a teardown (op_dispose=1), the running pointer starts at the start pointer plus 4 times the frame immediate. The block visits mask bits from 11 down to 0. For each set bit it reads the word at the running pointer into register 20+i and then raises the pointer by 4. The pointer written back is the final running pointer. A teardown with the same mask and immediate as the build before it therefore restores every selected register and the original pointer.
- R4: Clear mask bits cost no memory access, and the registers they name are never written. The number of accepted accesses equals the number of set mask bits.
- R5: At completion of a teardown with a nonzero return index, jump_valid is 1 and jump_target is the value of that register after all reloads. A return index of zero, or any build, gives jump_valid=0.
- R6: While a memory request waits for mem_ready, the request, address, write enable and write data all stay unchanged.
- R7: done is a single-cycle pulse, and sp_we is high in that same cycle with the new pointer on sp_out.
- R8: A start pulse that arrives while busy is high has no effect on the sequence in progress or on its results.
- R9: With an all-zero mask, the block makes no memory access. It asserts done in the first cycle after the start cycle, having applied only the frame adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op_dispose | input | 1 | 0 = build frame, 1 = tear down frame |
| reg_list | input | 12 | Bit i selects register 20+i |
| frame_imm | input | 5 | Local area size in words |
| ret_idx | input | 5 | Return register for teardown, 0 = none |
| sp_in | input | 32 | Stack pointer value at start |
| sp_out | output | 32 | New stack pointer, valid with sp_we |
| sp_we | output | 1 | Stack pointer write strobe |
| rf_idx | output | 5 | Register file index for read and write |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_wr | output | 1 | Register file write strobe |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| jump_valid | output | 1 | Teardown requests a jump |
| jump_target | output | 32 | Jump address |

## Verification
The hold and address-step checks assume two things about the surroundings. The register file is not changed by anyone else while a build runs, so that store data stays stable. The memory returns read data in the cycle it raises mem_ready. The bench drives the register file only between sequences. Its memory model answers reads combinationally with a ready that stalls at random, and the start pointers it picks are word aligned and keep every frame inside the modelled array.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int XLEN = 32,
  parameter int NREG = 12,
  parameter int BASE = 20,
  parameter int IMMW = 5,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_dispose,
  input  logic [NREG-1:0] reg_list,
  input  logic [IMMW-1:0] frame_imm,
  input  logic [IDXW-1:0] ret_idx,
  input  logic [XLEN-1:0] sp_in,
  output logic [XLEN-1:0] sp_out,
  output logic            sp_we,
  output logic [IDXW-1:0] rf_idx,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_wr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ready,
  output logic            busy,
  output logic            done,
  output logic            jump_valid,
  output logic [XLEN-1:0] jump_target
);
  localparam int STEP = XLEN / 8;
  localparam int CW = $clog2(NREG);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_FIN} st_t;

  st_t             st;
  logic            is_disp;
  logic [NREG-1:0] pend;
  logic [IMMW-1:0] imm_q;
  logic [IDXW-1:0] ret_q;
  logic [XLEN-1:0] wsp;
  logic [CW-1:0]   sel;
  logic [NREG-1:0] pend_next;
  logic [XLEN-1:0] frame_q, frame_in;
  logic            access, fire;

  // build takes the lowest pending bit, teardown the highest
  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++)
      if (pend[is_disp ? i : NREG - 1 - i]) sel = CW'(is_disp ? i : NREG - 1 - i);
  end

  assign pend_next = pend & ~(NREG'(1) << sel);
  assign frame_q   = XLEN'(imm_q) * XLEN'(STEP);
  assign frame_in  = XLEN'(frame_imm) * XLEN'(STEP);
  assign access    = (st == S_MEM);
  assign fire      = access && mem_ready;

  assign mem_req     = access;
  assign mem_we      = access && !is_disp;
  assign mem_addr    = is_disp ? wsp : wsp - XLEN'(STEP);
  assign mem_wdata   = rf_rdata;
  assign rf_idx      = (st == S_FIN) ? ret_q : IDXW'(BASE) + IDXW'(sel);
  assign rf_wr       = fire && is_disp;
  assign rf_wdata    = mem_rdata;
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign sp_we       = done;
  assign sp_out      = is_disp ? wsp : wsp - frame_q;
  assign jump_valid  = done && is_disp && (ret_q != '0);
  assign jump_target = rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_disp <= 1'b0;
      pend    <= '0;
      imm_q   <= '0;
      ret_q   <= '0;
      wsp     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          is_disp <= op_dispose;
          pend    <= reg_list;
          imm_q   <= frame_imm;
          ret_q   <= ret_idx;
          wsp     <= op_dispose ? sp_in + frame_in : sp_in;
          st      <= (reg_list != '0) ? S_MEM : S_FIN;
        end
        S_MEM: if (mem_ready) begin
          wsp  <= is_disp ? wsp + XLEN'(STEP) : wsp - XLEN'(STEP);
          pend <= pend_next;
          if (pend_next == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R1
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> !mem_req || (mem_we && mem_addr == $past(mem_addr) - XLEN'(STEP)));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> !mem_req || (!mem_we && mem_addr == $past(mem_addr) + XLEN'(STEP)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  reload_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> mem_req && mem_ready && !mem_we);

  // R5
  jump_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> done && rf_idx != '0);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_dispose = 1'b0;
  logic [11:0] reg_list = '0;
  logic [4:0]  frame_imm = '0;
  logic [4:0]  ret_idx = '0;
  logic [31:0] sp_in;
  logic [31:0] sp_out;
  logic        sp_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_rdata;
  logic        rf_wr;
  logic [31:0] rf_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        busy, done, jump_valid;
  logic [31:0] jump_target;

  logic [31:0] rf [32];
  logic [31:0] mem [256];
  logic [31:0] sp;
  int          acc_cnt;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_dispose(op_dispose),
    .reg_list(reg_list), .frame_imm(frame_imm), .ret_idx(ret_idx),
    .sp_in(sp_in), .sp_out(sp_out), .sp_we(sp_we),
    .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_wr(rf_wr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .jump_valid(jump_valid), .jump_target(jump_target)
  );

  assign sp_in     = sp;
  assign rf_rdata  = rf[rf_idx];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (rf_wr) rf[rf_idx] <= rf_wdata;
    if (sp_we) sp <= sp_out;
    if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  function automatic int ones(input logic [11:0] v);
    int n = 0;
    for (int i = 0; i < 12; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] got_sp, got_jt;
  logic        got_jv;
  int          got_cyc;

  task automatic run_op(input bit op, input logic [11:0] lst, input logic [4:0] imm,
                        input logic [4:0] ret, input bit poke);
    @(negedge clk);
    acc_cnt = 0;
    op_dispose = op; reg_list = lst; frame_imm = imm; ret_idx = ret;
    start = 1'b1;
    got_cyc = 0;
    forever begin
      @(negedge clk);
      got_cyc++;
      start = 1'b0;
      if (poke && got_cyc == 1) begin
        op_dispose = ~op; reg_list = 12'h001; frame_imm = 5'd31; ret_idx = 5'd1;
        start = 1'b1;
      end
      if (done) begin
        got_sp = sp_out; got_jv = jump_valid; got_jt = jump_target;
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  logic [31:0] orig [32];

  task automatic round(input logic [31:0] sp0, input logic [11:0] lst,
                       input logic [4:0] imm, input logic [4:0] ret, input bit poke);
    logic [31:0] a, e;
    int pc;
    pc = ones(lst);
    sp = sp0;
    for (int i = 1; i < 32; i++) begin rf[i] = $urandom; orig[i] = rf[i]; end
    rf[0] = '0; orig[0] = '0;
    run_op(1'b0, lst, imm, ret, poke);
    chk(got_sp == sp0 - 32'(pc * 4) - 32'(imm) * 4, "R2 build sp", got_sp, sp0 - 32'(pc * 4) - 32'(imm) * 4);
    chk(sp == got_sp, "R7 sp written", sp, got_sp);
    chk(acc_cnt == pc, "R4 access count", 32'(acc_cnt), 32'(pc));
    chk(!got_jv, "R5 no jump on build", {31'd0, got_jv}, 32'd0);
    if (pc == 0) chk(got_cyc == 1, "R9 empty list latency", 32'(got_cyc), 32'd1);
    a = sp0;
    for (int i = 0; i < 12; i++)
      if (lst[i]) begin
        a -= 4;
        chk(mem[a[9:2]] == orig[20 + i], "R1 saved word", mem[a[9:2]], orig[20 + i]);
      end
    for (int i = 20; i < 32; i++) rf[i] = ~orig[i];
    run_op(1'b1, lst, imm, ret, 1'b0);
    chk(got_sp == sp0, "R3 restored sp", got_sp, sp0);
    chk(acc_cnt == pc, "R4 reload count", 32'(acc_cnt), 32'(pc));
    for (int i = 20; i < 32; i++) begin
      e = lst[i - 20] ? orig[i] : ~orig[i];
      chk(rf[i] == e, lst[i - 20] ? "R3 reloaded reg" : "R4 untouched reg", rf[i], e);
    end
    chk(got_jv == (ret != 0), "R5 jump valid", {31'd0, got_jv}, {31'd0, ret != 0});
    if (ret != 0) chk(got_jt == rf[ret], "R5 jump target", got_jt, rf[ret]);
    if (poke) chk(sp == sp0, "R8 busy start ignored", sp, sp0);
  endtask

  initial begin
    int s;
    s = $urandom(32'd4711);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    sp = 32'h300;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !sp_we, "R7 reset idle",
        {28'd0, busy, done, mem_req, sp_we}, 32'd0);
    rst_n = 1'b1;
    round(32'h300, 12'h000, 5'd7, 5'd0, 1'b0);
    round(32'h300, 12'h000, 5'd0, 5'd25, 1'b0);
    round(32'h3F0, 12'hFFF, 5'd31, 5'd31, 1'b0);
    round(32'h240, 12'h801, 5'd0, 5'd0, 1'b0);
    round(32'h280, 12'hFFF, 5'd3, 5'd20, 1'b1);
    for (int k = 0; k < 40; k++)
      round(32'h200 + 32'($urandom % 124) * 4, 12'($urandom), 5'($urandom),
            (k % 4 == 0) ? 5'd0 : 5'($urandom), 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule